// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits beside a two-port shared memory and turns ordinary accesses to the two highest word addresses into doorbell interrupts between the ports. The all-ones address is the mailbox owned by the right port. The address one below it is the mailbox owned by the left port. When a port writes into the peer's mailbox, the peer's interrupt flag is raised. The owner drops its flag by reading its own mailbox. The message words themselves live in the shared array and are not part of this block. The block only watches the access controls and keeps one registered flag per port.

Each port presents its chip enable, read/write select, output enable, address and an arbitration busy input every clock. An access that is flagged busy toward its port leaves both flags alone, whether it would have set or cleared one. All pins are plain control and status levels, sampled on the rising clock edge. There is no data stream and no valid/ready handshake, so no back-pressure applies.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While rst_n is low, both lt_irq and rt_irq are 0. They are still 0 on the first cycle after reset is released.
- R2: A left write sets rt_irq to 1 one cycle after the edge that samples it. A left write is lt_en=1 and lt_rnw=0, to address all-ones, with lt_busy=0.
- R3: A right write sets lt_irq to 1 one cycle after the edge that samples it. A right write is rt_en=1 and rt_rnw=0, to address all-ones minus one, with rt_busy=0.
- R4: A port's read of its own mailbox clears that port's flag on the next cycle. A read is en=1, rnw=1, oe=1 and busy=0. The left mailbox is all-ones minus one and the right mailbox is all-ones.
- R5: A port's read of the peer's mailbox changes neither flag.
- R6: With busy high on the writing port, a write into the peer's mailbox does not set the peer's flag.
- R7: With busy high on the owner port, a read of its own mailbox does not clear its flag.
- R8: If a set and a clear reach the same flag in one cycle, the flag ends up 1.
- R9: These accesses change neither flag:
  - an access with en=0;
  - a read with oe=0;
  - a write to any other address, including the writer's own mailbox.
- R10: With no set or clear event, each flag keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_en | input | 1 | Left chip enable, active high |
| lt_rnw | input | 1 | Left read (1) / write (0) select |
| lt_oe | input | 1 | Left output enable, active high |
| lt_addr | input | AW | Left word address |
| lt_busy | input | 1 | Left arbitration busy, active high |
| rt_en | input | 1 | Right chip enable, active high |
| rt_rnw | input | 1 | Right read (1) / write (0) select |
| rt_oe | input | 1 | Right output enable, active high |
| rt_addr | input | AW | Right word address |
| rt_busy | input | 1 | Right arbitration busy, active high |
| lt_irq | output | 1 | Left port interrupt flag |
| rt_irq | output | 1 | Right port interrupt flag |

## Verification
The stimulus posts to each mailbox and then clears it by an owner read. Between the set and the clear, it tries reads of the peer's mailbox, writes to the writer's own mailbox, accesses with the enable or output enable low, and busy-marked accesses. Each of these would show a flag that moves when it should not. A cycle where one port reads its own mailbox while the other port posts to it tells a set-priority register apart from a clear-priority one. Posts and clears on both ports in the same cycle show that the two flags are decoded independently, with no cross-wired address.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Reads need enable and output enable; writes need enable with rnw low.
  function automatic acc_e classify(input logic en, input logic rnw, input logic oe);
    if (!en)
      return ACC_IDLE;
    else if (!rnw)
      return ACC_WRITE;
    else if (oe)
      return ACC_READ;
    else
      return ACC_IDLE;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int AW         = 15,
  parameter bit OWN_IS_TOP = 1'b0
) (
  input  logic          en,
  input  logic          rnw,
  input  logic          oe,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  output logic          post_peer,
  output logic          claim_own
);
  localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;
  localparam logic [AW-1:0] OWN_ADDR  = OWN_IS_TOP ? TOP_ADDR : NEXT_ADDR;
  localparam logic [AW-1:0] PEER_ADDR = OWN_IS_TOP ? NEXT_ADDR : TOP_ADDR;

  acc_e kind;

  always_comb begin
    kind      = classify(en, rnw, oe);
    post_peer = (kind == ACC_WRITE) && (addr == PEER_ADDR) && !busy;
    claim_own = (kind == ACC_READ)  && (addr == OWN_ADDR)  && !busy;
  end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= 1'b0;
    else if (set)
      q <= 1'b1;
    else if (clr)
      q <= 1'b0;
  end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lt_en,
  input  logic          lt_rnw,
  input  logic          lt_oe,
  input  logic [AW-1:0] lt_addr,
  input  logic          lt_busy,
  input  logic          rt_en,
  input  logic          rt_rnw,
  input  logic          rt_oe,
  input  logic [AW-1:0] rt_addr,
  input  logic          rt_busy,
  output logic          lt_irq,
  output logic          rt_irq
);
  localparam int NPORT = 2;

  logic          p_en   [NPORT];
  logic          p_rnw  [NPORT];
  logic          p_oe   [NPORT];
  logic [AW-1:0] p_addr [NPORT];
  logic          p_busy [NPORT];
  logic          p_post [NPORT];
  logic          p_claim[NPORT];
  logic          p_irq  [NPORT];

  // Index 0 is the left port, index 1 the right port.
  always_comb begin
    p_en[0]   = lt_en;   p_en[1]   = rt_en;
    p_rnw[0]  = lt_rnw;  p_rnw[1]  = rt_rnw;
    p_oe[0]   = lt_oe;   p_oe[1]   = rt_oe;
    p_addr[0] = lt_addr; p_addr[1] = rt_addr;
    p_busy[0] = lt_busy; p_busy[1] = rt_busy;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port_decode #(
      .AW        (AW),
      .OWN_IS_TOP(p == 1)
    ) u_dec (
      .en       (p_en[p]),
      .rnw      (p_rnw[p]),
      .oe       (p_oe[p]),
      .addr     (p_addr[p]),
      .busy     (p_busy[p]),
      .post_peer(p_post[p]),
      .claim_own(p_claim[p])
    );

    // The flag of port p is posted by the peer and claimed by p itself.
    mbx_irq_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (p_post[NPORT-1-p]),
      .clr  (p_claim[p]),
      .q    (p_irq[p])
    );
  end

  assign lt_irq = p_irq[0];
  assign rt_irq = p_irq[1];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lt_en,
  input logic          lt_rnw,
  input logic          lt_oe,
  input logic [AW-1:0] lt_addr,
  input logic          lt_busy,
  input logic          rt_en,
  input logic          rt_rnw,
  input logic          rt_oe,
  input logic [AW-1:0] rt_addr,
  input logic          rt_busy,
  input logic          lt_irq,
  input logic          rt_irq
);
  localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;

  logic lt_posts, rt_posts, lt_reads_own, rt_reads_own;
  always_comb begin
    lt_posts     = lt_en && !lt_rnw && lt_addr == TOP_ADDR  && !lt_busy;
    rt_posts     = rt_en && !rt_rnw && rt_addr == NEXT_ADDR && !rt_busy;
    lt_reads_own = lt_en && lt_rnw && lt_oe && lt_addr == NEXT_ADDR && !lt_busy;
    rt_reads_own = rt_en && rt_rnw && rt_oe && rt_addr == TOP_ADDR  && !rt_busy;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!lt_irq && !rt_irq));

  // R2
  left_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_posts |=> rt_irq);

  // R3
  right_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_posts |=> lt_irq);

  // R4
  right_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_reads_own && !lt_posts) |=> !rt_irq);

  // R4
  left_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_reads_own && !rt_posts) |=> !lt_irq);

  // R6
  busy_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_busy && !rt_irq) |=> !rt_irq);

  // R7
  busy_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_busy && rt_irq) |=> rt_irq);

  // R10
  hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_posts && !lt_reads_own) |=> $stable(lt_irq));
endmodule

bind mbx_irq_ctrl mbx_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lt_en(lt_en), .lt_rnw(lt_rnw), .lt_oe(lt_oe), .lt_addr(lt_addr), .lt_busy(lt_busy),
  .rt_en(rt_en), .rt_rnw(rt_rnw), .rt_oe(rt_oe), .rt_addr(rt_addr), .rt_busy(rt_busy),
  .lt_irq(lt_irq), .rt_irq(rt_irq)
);

// File: tb/sim_mbx_irq_ctrl.sv
module sim_mbx_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = TOP - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lt_en = 0, lt_rnw = 1, lt_oe = 0, lt_busy = 0;
  logic rt_en = 0, rt_rnw = 1, rt_oe = 0, rt_busy = 0;
  logic [AW-1:0] lt_addr = '0, rt_addr = '0;
  logic lt_irq, rt_irq;

  typedef struct {
    logic  el;
    logic  er;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_irq_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lt_en(lt_en), .lt_rnw(lt_rnw), .lt_oe(lt_oe), .lt_addr(lt_addr), .lt_busy(lt_busy),
    .rt_en(rt_en), .rt_rnw(rt_rnw), .rt_oe(rt_oe), .rt_addr(rt_addr), .rt_busy(rt_busy),
    .lt_irq(lt_irq), .rt_irq(rt_irq)
  );

  // Monitor: compare the flags just after each edge against the queued item.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (lt_irq !== e.el || rt_irq !== e.er) begin
        n_fail++;
        $display("FAIL %s: lt_irq=%b rt_irq=%b expected lt_irq=%b rt_irq=%b",
                 e.tag, lt_irq, rt_irq, e.el, e.er);
      end
    end
  end

  task automatic drv_lt(input logic en, input logic rnw, input logic oe,
                        input logic [AW-1:0] a, input logic busy);
    lt_en = en; lt_rnw = rnw; lt_oe = oe; lt_addr = a; lt_busy = busy;
  endtask

  task automatic drv_rt(input logic en, input logic rnw, input logic oe,
                        input logic [AW-1:0] a, input logic busy);
    rt_en = en; rt_rnw = rnw; rt_oe = oe; rt_addr = a; rt_busy = busy;
  endtask

  // Driver: inputs are set at a falling edge; queue the expected flags for the next rising edge.
  task automatic cyc(input logic el, input logic er, input string tag);
    exp_t e;
    e.el = el; e.er = er; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    drv_lt(0, 1, 0, '0, 0);
    drv_rt(0, 1, 0, '0, 0);
  endtask

  initial begin
    @(negedge clk);
    cyc(0, 0, "R1 in reset");
    drv_lt(1, 0, 0, TOP, 0);          // post attempt while reset held
    cyc(0, 0, "R1 post ignored in reset");
    rst_n = 1'b1;
    cyc(0, 0, "R1 after release");
    drv_lt(1, 0, 0, NEXT, 0);         // left writes its own mailbox
    cyc(0, 0, "R9 write own mailbox");
    drv_lt(1, 0, 0, TOP, 0);
    cyc(0, 1, "R2 left posts");
    cyc(0, 1, "R10 hold");
    drv_lt(1, 1, 1, TOP, 0);          // left reads peer's mailbox
    cyc(0, 1, "R5 left reads peer mailbox");
    drv_rt(1, 1, 0, TOP, 0);
    cyc(0, 1, "R9 read without oe");
    drv_rt(0, 1, 1, TOP, 0);
    cyc(0, 1, "R9 read without enable");
    drv_rt(1, 1, 1, TOP, 1);
    cyc(0, 1, "R7 busy blocks clear");
    drv_rt(1, 1, 1, TOP, 0);
    cyc(0, 0, "R4 right claims");
    drv_lt(1, 0, 0, TOP, 1);
    cyc(0, 0, "R6 busy blocks set");
    drv_rt(1, 0, 0, NEXT, 0);
    cyc(1, 0, "R3 right posts");
    drv_rt(1, 1, 1, NEXT, 0);
    cyc(1, 0, "R5 right reads peer mailbox");
    drv_lt(1, 1, 1, NEXT, 0);
    drv_rt(1, 0, 0, NEXT, 0);
    cyc(1, 0, "R8 set beats clear");
    drv_lt(1, 1, 1, NEXT, 0);
    cyc(0, 0, "R4 left claims");
    drv_lt(1, 0, 0, AW'(16'h1234), 0);
    drv_rt(1, 0, 0, AW'(16'h0042), 0);
    cyc(0, 0, "R9 other addresses");
    drv_lt(1, 0, 0, TOP, 0);
    drv_rt(1, 0, 0, NEXT, 0);
    cyc(1, 1, "R2 R3 both post");
    drv_rt(1, 0, 0, NEXT, 1);
    cyc(1, 1, "R6 busy right post");
    drv_lt(1, 1, 1, NEXT, 1);
    drv_rt(1, 1, 1, TOP, 0);
    cyc(1, 0, "R7 left busy keeps, R4 right clears");
    drv_lt(1, 1, 1, NEXT, 0);
    cyc(0, 0, "R4 left clears");
    cyc(0, 0, "R10 idle hold");
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 2000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule